// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the slave-side controller for the word-granular auto-increment program mode of an SPI serial flash. It turns the serial command stream into paired byte writes toward the memory array. A frame is one chip-select low period. Only the frame that enters the mode carries a start address. After that, each short frame carries two data bytes and programs the next word. The running word address is held inside the block between frames.

The serial side is sampled by the system clock. `spi_sck_rise` is a one-cycle strobe that marks a rising serial clock edge, and `spi_mosi` is taken MSB first on that strobe. A command takes effect when chip select rises, and only if the frame holds exactly the right number of whole bytes. Each word program holds the block busy for `PROG_CYCLES` clocks. A status read works at any time. After an enable command, SO can also report ready or busy while the mode is active.

Opcodes are fixed. `ADh` starts or continues the program mode, `06h` sets the write-enable latch, and `04h` clears it. `05h` reads status. `70h` turns the busy indication on SO on, and `80h` turns it off.

Top module: `aai_word_prog`

## Requirements
- R1: An `ADh` frame does nothing unless the write-enable latch was set beforehand by a one-byte `06h` frame.
- R2: Outside the mode, a frame of `ADh`, three address bytes (most significant first) and two data bytes enters the mode. Let W be address bits AW-1..1. The block writes data byte 0 to address {W,0} and, on the next clock, data byte 1 to address {W,1}.
- R3: Inside the mode, a frame of `ADh` followed by two data bytes programs word W+1 in the same order as R2.
- R4: The word address wraps from the top word of the array to word zero.
- R5: Each word program keeps the block busy for `PROG_CYCLES` clocks. An `ADh` frame that ends while the block is busy is ignored, and the word address does not advance.
- R6: Opcode `05h` returns a status byte MSB first on SO for as long as the frame lasts, and the byte is re-sampled after every 8 bits. Bit 0 is busy, bit 1 is the write-enable latch, bit 6 is mode active, and all other bits are 0.
- R7: While the mode is active, every command except `ADh`, `05h` and `04h` is ignored. This includes `70h` and `80h`.
- R8: After a one-byte `70h` frame outside the mode, SO is enabled whenever chip select is low and the mode is active, with SO = 1 for ready and 0 for busy.
- R9: A one-byte `80h` frame outside the mode turns off the busy indication on SO.
- R10: A one-byte `04h` frame ends the mode and clears the write-enable latch. A later 3-byte `ADh` frame is then ignored.
- R11: A frame with a partial trailing byte, or with a byte count other than the one its command needs, is ignored.
- R12: After reset there is no array write, SO is not enabled, and the status byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low, synchronous to clk |
| spi_sck_rise | input | 1 | One-cycle strobe per rising serial clock edge |
| spi_mosi | input | 1 | Serial data in, sampled on the strobe |
| spi_so | output | 1 | Serial data out (status or ready/busy) |
| spi_so_oe | output | 1 | Output enable for SO |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | AW | Array byte address |
| arr_wdata | output | 8 | Array byte data |

## Verification
Some properties are checked on every cycle:
- Every array write needs the write-enable latch.
- Each even-address write is followed by its odd partner on the next clock.
- No word starts while the block is busy.
- SO is never enabled with chip select high.

Other behaviours show only in the bench scenarios:
- The word sequence across frames, including the wrap to zero.
- The status byte contents.
- Frames that are ignored because of byte count, busy or mode.
- The busy indication turning on and off.

// File: rtl/aai_pkg.sv
package aai_pkg;

    localparam logic [7:0] OPC_AAI     = 8'hAD;
    localparam logic [7:0] OPC_WREN    = 8'h06;
    localparam logic [7:0] OPC_WRDI    = 8'h04;
    localparam logic [7:0] OPC_RDSR    = 8'h05;
    localparam logic [7:0] OPC_RB_ON   = 8'h70;
    localparam logic [7:0] OPC_RB_OFF  = 8'h80;

    localparam int ST_BUSY = 0;
    localparam int ST_WEL  = 1;
    localparam int ST_MODE = 6;

    localparam logic [2:0] LEN_ENTRY = 3'd6;
    localparam logic [2:0] LEN_NEXT  = 3'd3;
    localparam logic [2:0] LEN_CMD   = 3'd1;

    typedef struct packed {
        logic       cs;
        logic [6:0] sh;
        logic [2:0] bitcnt;
        logic [2:0] nbytes;
        logic       vld;
        logic [7:0] data;
        logic [2:0] idx;
    } rx_state_t;

endpackage

// File: rtl/aai_byte_rx.sv
module aai_byte_rx
    import aai_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck_rise,
    input  logic       mosi,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic [2:0] byte_idx,
    output logic       frame_end,
    output logic [2:0] frame_bytes,
    output logic       frame_whole,
    output logic       bit_tick
);

    rx_state_t rx_d, rx_q;

    always_comb begin
        rx_d     = rx_q;
        rx_d.vld = 1'b0;
        rx_d.cs  = cs_n;
        if (cs_n) begin
            rx_d.bitcnt = '0;
            rx_d.nbytes = '0;
        end else if (sck_rise) begin
            rx_d.sh     = {rx_q.sh[5:0], mosi};
            rx_d.bitcnt = rx_q.bitcnt + 3'd1;
            if (rx_q.bitcnt == 3'd7) begin
                rx_d.vld  = 1'b1;
                rx_d.data = {rx_q.sh, mosi};
                rx_d.idx  = rx_q.nbytes;
                if (rx_q.nbytes != 3'd7) begin
                    rx_d.nbytes = rx_q.nbytes + 3'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q    <= '0;
            rx_q.cs <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_vld    = rx_q.vld;
    assign byte_data   = rx_q.data;
    assign byte_idx    = rx_q.idx;
    assign frame_end   = cs_n & ~rx_q.cs;
    assign frame_bytes = rx_q.nbytes;
    assign frame_whole = (rx_q.bitcnt == 3'd0);
    assign bit_tick    = sck_rise & ~cs_n;

endmodule

// File: rtl/aai_prog_timer.sv
module aai_prog_timer #(
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int TW = $clog2(PROG_CYCLES + 1);
    localparam logic [TW-1:0] LOAD = TW'(PROG_CYCLES);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/aai_cmd_ctrl.sv
module aai_cmd_ctrl
    import aai_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          byte_vld,
    input  logic [7:0]    byte_data,
    input  logic [2:0]    byte_idx,
    input  logic          frame_end,
    input  logic [2:0]    frame_bytes,
    input  logic          frame_whole,
    input  logic          bit_tick,
    input  logic          tmr_busy,
    output logic          tmr_start,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [7:0]    arr_wdata,
    output logic          so,
    output logic          so_oe,
    output logic          wel,
    output logic          mode,
    output logic          busy
);

    localparam int WAW = AW - 1;

    typedef struct packed {
        logic            wel;
        logic            mode;
        logic            rb_en;
        logic            rd_act;
        logic [7:0]      opc;
        logic [4:0][7:0] bufb;
        logic [WAW-1:0]  waddr;
        logic            wr_ph;
        logic [7:0]      d1;
        logic            we;
        logic [AW-1:0]   addr;
        logic [7:0]      wdata;
        logic [7:0]      sosh;
    } ctl_state_t;

    ctl_state_t c_d, c_q;

    logic           busy_now;
    logic [7:0]     status;
    logic [23:0]    a24;
    logic           go;
    logic [WAW-1:0] go_waddr;
    logic [7:0]     go_d0;
    logic [7:0]     go_d1;

    always_comb begin
        busy_now = tmr_busy | c_q.wr_ph;
        status          = '0;
        status[ST_BUSY] = busy_now;
        status[ST_WEL]  = c_q.wel;
        status[ST_MODE] = c_q.mode;
        a24 = {c_q.bufb[0], c_q.bufb[1], c_q.bufb[2]};

        c_d       = c_q;
        c_d.we    = 1'b0;
        tmr_start = 1'b0;
        go        = 1'b0;
        go_waddr  = c_q.waddr;
        go_d0     = '0;
        go_d1     = '0;

        if (c_q.wr_ph) begin
            c_d.we    = 1'b1;
            c_d.addr  = {c_q.waddr, 1'b1};
            c_d.wdata = c_q.d1;
            c_d.wr_ph = 1'b0;
        end

        if (bit_tick && c_q.rd_act) begin
            c_d.sosh = {c_q.sosh[6:0], 1'b0};
        end

        if (byte_vld) begin
            if (byte_idx == 3'd0) begin
                c_d.opc = byte_data;
                if (byte_data == OPC_RDSR) begin
                    c_d.rd_act = 1'b1;
                    c_d.sosh   = status;
                end
            end else begin
                if (byte_idx <= 3'd5) begin
                    c_d.bufb[byte_idx - 3'd1] = byte_data;
                end
                if (c_q.rd_act) begin
                    c_d.sosh = status;
                end
            end
        end

        if (frame_end) begin
            c_d.rd_act = 1'b0;
            if (frame_whole) begin
                case (c_q.opc)
                    OPC_WREN: begin
                        if (frame_bytes == LEN_CMD && !c_q.mode) c_d.wel = 1'b1;
                    end
                    OPC_WRDI: begin
                        if (frame_bytes == LEN_CMD) begin
                            c_d.wel  = 1'b0;
                            c_d.mode = 1'b0;
                        end
                    end
                    OPC_RB_ON: begin
                        if (frame_bytes == LEN_CMD && !c_q.mode) c_d.rb_en = 1'b1;
                    end
                    OPC_RB_OFF: begin
                        if (frame_bytes == LEN_CMD && !c_q.mode) c_d.rb_en = 1'b0;
                    end
                    OPC_AAI: begin
                        if (!busy_now && c_q.wel) begin
                            if (!c_q.mode && frame_bytes == LEN_ENTRY) begin
                                go       = 1'b1;
                                go_waddr = a24[AW-1:1];
                                go_d0    = c_q.bufb[3];
                                go_d1    = c_q.bufb[4];
                            end else if (c_q.mode && frame_bytes == LEN_NEXT) begin
                                go       = 1'b1;
                                go_waddr = c_q.waddr + 1'b1;
                                go_d0    = c_q.bufb[0];
                                go_d1    = c_q.bufb[1];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end

        if (go) begin
            c_d.mode  = 1'b1;
            c_d.waddr = go_waddr;
            c_d.we    = 1'b1;
            c_d.addr  = {go_waddr, 1'b0};
            c_d.wdata = go_d0;
            c_d.d1    = go_d1;
            c_d.wr_ph = 1'b1;
            tmr_start = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign arr_we    = c_q.we;
    assign arr_addr  = c_q.addr;
    assign arr_wdata = c_q.wdata;
    assign so_oe     = ~cs_n & (c_q.rd_act | (c_q.rb_en & c_q.mode));
    assign so        = c_q.rd_act ? c_q.sosh[7] : ~busy_now;
    assign wel       = c_q.wel;
    assign mode      = c_q.mode;
    assign busy      = busy_now;

endmodule

// File: rtl/aai_word_prog.sv
module aai_word_prog
    import aai_pkg::*;
#(
    parameter int AW          = 20,
    parameter int PROG_CYCLES = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_cs_n,
    input  logic          spi_sck_rise,
    input  logic          spi_mosi,
    output logic          spi_so,
    output logic          spi_so_oe,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [7:0]    arr_wdata
);

    logic       rx_vld;
    logic [7:0] rx_data;
    logic [2:0] rx_idx;
    logic       rx_fend;
    logic [2:0] rx_nbytes;
    logic       rx_whole;
    logic       rx_tick;
    logic       tmr_start;
    logic       tmr_busy;
    logic       aai_wel;
    logic       aai_mode;
    logic       aai_busy;

    aai_byte_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (spi_cs_n),
        .sck_rise    (spi_sck_rise),
        .mosi        (spi_mosi),
        .byte_vld    (rx_vld),
        .byte_data   (rx_data),
        .byte_idx    (rx_idx),
        .frame_end   (rx_fend),
        .frame_bytes (rx_nbytes),
        .frame_whole (rx_whole),
        .bit_tick    (rx_tick)
    );

    aai_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy)
    );

    aai_cmd_ctrl #(.AW(AW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (spi_cs_n),
        .byte_vld    (rx_vld),
        .byte_data   (rx_data),
        .byte_idx    (rx_idx),
        .frame_end   (rx_fend),
        .frame_bytes (rx_nbytes),
        .frame_whole (rx_whole),
        .bit_tick    (rx_tick),
        .tmr_busy    (tmr_busy),
        .tmr_start   (tmr_start),
        .arr_we      (arr_we),
        .arr_addr    (arr_addr),
        .arr_wdata   (arr_wdata),
        .so          (spi_so),
        .so_oe       (spi_so_oe),
        .wel         (aai_wel),
        .mode        (aai_mode),
        .busy        (aai_busy)
    );

endmodule

// File: rtl/aai_word_prog_chk.sv
module aai_word_prog_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          so_oe,
    input logic          arr_we,
    input logic [AW-1:0] arr_addr,
    input logic          busy,
    input logic          wel,
    input logic          mode
);

    a_r1_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wel);

    a_r2_odd_follows_even: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !arr_addr[0]) |=> (arr_we && arr_addr == {$past(arr_addr[AW-1:1]), 1'b1}));

    a_r2_odd_has_even: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && arr_addr[0]) |-> ($past(arr_we) && !$past(arr_addr[0])));

    a_r5_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !arr_addr[0]) |-> !$past(busy));

    a_r2_mode_entry_writes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode) |-> arr_we);

    a_r8_so_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !cs_n);

endmodule

bind aai_word_prog aai_word_prog_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (spi_cs_n),
    .so_oe    (spi_so_oe),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .busy     (aai_busy),
    .wel      (aai_wel),
    .mode     (aai_mode)
);

// File: tb/aai_word_prog_tb.sv
module aai_word_prog_tb;

    localparam int AW   = 20;
    localparam int PROG = 150;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_sck_rise = 1'b0;
    logic          spi_mosi = 1'b0;
    logic          spi_so;
    logic          spi_so_oe;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;

    always #2 clk = ~clk;

    aai_word_prog #(.AW(AW), .PROG_CYCLES(PROG)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_cs_n     (spi_cs_n),
        .spi_sck_rise (spi_sck_rise),
        .spi_mosi     (spi_mosi),
        .spi_so       (spi_so),
        .spi_so_oe    (spi_so_oe),
        .arr_we       (arr_we),
        .arr_addr     (arr_addr),
        .arr_wdata    (arr_wdata)
    );

    int nvec = 0;
    int nfail = 0;
    longint cyc = 0;
    bit done = 1'b0;

    logic [7:0] txb [8];
    logic [7:0] rxb [8];

    // behavioural reference state
    bit     m_wel = 0, m_mode = 0, m_rb = 0, m_exec = 0;
    int     m_waddr = 0;
    longint m_last = 0;
    int     q_addr[$];
    int     q_data[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    function automatic bit m_busy();
        return m_exec && ((cyc - m_last) <= PROG);
    endfunction

    task automatic m_program(input int w, input int d0, input int d1);
        m_waddr = w & ((1 << (AW-1)) - 1);
        q_addr.push_back(m_waddr * 2);     q_data.push_back(d0);
        q_addr.push_back(m_waddr * 2 + 1); q_data.push_back(d1);
        m_mode = 1; m_exec = 1; m_last = cyc;
    endtask

    task automatic model_apply(input int n, input bit whole);
        if (!whole || n == 0) return;
        case (txb[0])
            8'h06: if (n == 1 && !m_mode) m_wel = 1;
            8'h04: if (n == 1) begin m_wel = 0; m_mode = 0; end
            8'h70: if (n == 1 && !m_mode) m_rb = 1;
            8'h80: if (n == 1 && !m_mode) m_rb = 0;
            8'hAD: if (!m_busy() && m_wel) begin
                if (!m_mode && n == 6)
                    m_program(int'({txb[1], txb[2], txb[3]}) >> 1, txb[4], txb[5]);
                else if (m_mode && n == 3)
                    m_program(m_waddr + 1, txb[1], txb[2]);
            end
            default: ;
        endcase
    endtask

    // every clock: compare array writes with the model queue
    always @(negedge clk) begin
        if (rst_n && arr_we && !done) begin
            if (q_addr.size() == 0) begin
                chk(0, "R1|R5|R7|R10|R11 unexpected write", int'(arr_addr), -1);
            end else begin
                int ea, ed;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                chk(int'(arr_addr) == ea, "R2|R3|R4 write address", int'(arr_addr), ea);
                chk(int'(arr_wdata) == ed, "R2|R3 write data", int'(arr_wdata), ed);
            end
        end
    end

    task automatic send_bit(input logic v, input int bi, input int bp);
        @(negedge clk);
        spi_mosi = v;
        rxb[bi][bp] = spi_so;
        spi_sck_rise = 1'b1;
        @(negedge clk);
        spi_sck_rise = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input int nb, input int extra);
        @(negedge clk);
        spi_cs_n = 1'b0;
        for (int i = 0; i < nb; i++)
            for (int b = 7; b >= 0; b--) send_bit(txb[i][b], i, b);
        for (int k = 0; k < extra; k++) send_bit(1'b0, 7, 0);
        repeat (3) @(negedge clk);
        spi_cs_n = 1'b1;
        model_apply(nb, extra == 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        txb[0] = op;
        xfer(1, 0);
    endtask

    task automatic aai_first(input int a, input int d0, input int d1);
        txb[0] = 8'hAD; txb[1] = 8'(a >> 16); txb[2] = 8'(a >> 8); txb[3] = 8'(a);
        txb[4] = 8'(d0); txb[5] = 8'(d1);
        xfer(6, 0);
    endtask

    task automatic aai_next(input int d0, input int d1, input int extra);
        txb[0] = 8'hAD; txb[1] = 8'(d0); txb[2] = 8'(d1);
        xfer(3, extra);
    endtask

    task automatic rdsr(input int nrep);
        txb[0] = 8'h05;
        for (int i = 1; i < 8; i++) txb[i] = 8'h00;
        xfer(1 + nrep, 0);
    endtask

    function automatic int m_status(input bit busyf);
        return (int'(m_mode) << 6) | (int'(m_wel) << 1) | int'(busyf);
    endfunction

    task automatic probe_so(output logic oe, output logic so);
        @(negedge clk);
        spi_cs_n = 1'b0;
        #1;
        oe = spi_so_oe;
        so = spi_so;
        @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            chk(0, "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic oe, so;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R12 reset state
        chk(arr_we == 1'b0, "R12 no write after reset", arr_we, 0);
        probe_so(oe, so);
        chk(oe == 1'b0, "R12 SO disabled after reset", oe, 0);
        rdsr(1);
        chk(rxb[1] == 8'h00, "R12 status after reset", rxb[1], 0);

        // R1 program without write enable is ignored
        aai_first(20'h12344, 8'hA1, 8'hB2);
        repeat (20) @(negedge clk);
        rdsr(1);
        chk(rxb[1] == 8'h00, "R1 no mode without WEL", rxb[1], 0);

        // R1 write enable sets the latch
        cmd1(8'h06);
        rdsr(1);
        chk(rxb[1] == 8'h02, "R1 WEL in status", rxb[1], 8'h02);

        // R11 entry frame with wrong length ignored
        txb[0] = 8'hAD; txb[1] = 8'h01; txb[2] = 8'h23; txb[3] = 8'h44; txb[4] = 8'h55;
        xfer(5, 0);
        rdsr(1);
        chk(rxb[1] == m_status(0), "R11 short entry frame ignored", rxb[1], m_status(0));

        // R8 enable ready/busy on SO, then enter mode
        cmd1(8'h70);
        aai_first(20'h12344, 8'hA1, 8'hB2);
        probe_so(oe, so);
        chk(oe == 1'b1, "R8 SO enabled in mode", oe, 1);
        chk(so == 1'b0, "R8 SO shows busy", so, 0);
        rdsr(1);
        chk(rxb[1] == 8'h43, "R6 status busy in mode", rxb[1], 8'h43);
        repeat (PROG + 40) @(negedge clk);
        probe_so(oe, so);
        chk(oe == 1'b1 && so == 1'b1, "R8 SO shows ready", {oe, so}, 3);

        // R6 continuous status read
        rdsr(2);
        chk(rxb[1] == 8'h42, "R6 status first byte", rxb[1], 8'h42);
        chk(rxb[2] == 8'h42, "R6 status repeated byte", rxb[2], 8'h42);

        // R3 next word, then R5 frame while busy ignored
        aai_next(8'hC3, 8'hD4, 0);
        aai_next(8'h99, 8'h88, 0);
        repeat (PROG + 40) @(negedge clk);
        aai_next(8'hE5, 8'hF6, 0);
        repeat (PROG + 40) @(negedge clk);
        chk(m_waddr == (20'h12348 >> 1), "R5 address held over busy frame", m_waddr, 20'h12348 >> 1);

        // R7 display disable ignored inside the mode
        cmd1(8'h80);
        probe_so(oe, so);
        chk(oe == 1'b1, "R7 disable ignored in mode", oe, 1);

        // R11 partial trailing byte and wrong count ignored
        aai_next(8'h10, 8'h20, 3);
        repeat (PROG + 40) @(negedge clk);
        txb[0] = 8'hAD; txb[1] = 8'h30; txb[2] = 8'h40; txb[3] = 8'h50;
        xfer(4, 0);
        repeat (PROG + 40) @(negedge clk);

        // R10 write disable ends mode
        cmd1(8'h04);
        rdsr(1);
        chk(rxb[1] == 8'h00, "R10 status after exit", rxb[1], 0);
        probe_so(oe, so);
        chk(oe == 1'b0, "R10 SO off after exit", oe, 0);
        aai_next(8'h66, 8'h77, 0);
        repeat (PROG + 40) @(negedge clk);

        // R9 display disable, then R4 wrap at the top word
        cmd1(8'h06);
        cmd1(8'h80);
        aai_first(20'hFFFFE, 8'h11, 8'h22);
        probe_so(oe, so);
        chk(oe == 1'b0, "R9 SO stays off after disable", oe, 0);
        repeat (PROG + 40) @(negedge clk);
        aai_next(8'h33, 8'h44, 0);
        repeat (PROG + 40) @(negedge clk);
        chk(m_waddr == 0, "R4 model wrapped", m_waddr, 0);

        repeat (10) @(negedge clk);
        chk(q_addr.size() == 0, "R2|R3|R4 expected writes missing", q_addr.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule